// File: doc/BRIEF.md
# Chunk Dependence Ordering Unit

This unit sits beside the shared first-level cache of a simultaneously multithreaded core in which every hardware thread runs atomic chunks. When a thread reads a line whose tag bits show that it was written by another thread's uncommitted chunk, the cache reports the access together with the writer's thread number. The unit then resolves the dependence under one of three selectable policies:

- **Squash:** the reading chunk is squashed.
- **Stall:** the reading thread is held until the writing chunk commits.
- **Order:** both chunks keep running, and the reader's commit is held back until the writer has committed.

Dependences are kept in a square bit matrix, one row and one column per thread. Bit (i, j) set means thread i depends on thread j. Commit requests are granted one per cycle, round-robin, and only to threads whose row is empty.

A granted commit clears the committing thread's column. A squash is passed on to every thread that depends, directly or through other threads, on the squashed one, and the rows and columns of all squashed threads are cleared. A new dependence that would close a loop in the matrix squashes the reading thread instead of being recorded.

Top module: `chunk_order_unit`

## Requirements
- R1: After a synchronous reset, `grant_o`, `squash_o` and `stall_o` are all zero and the matrix is empty, so any commit request is grantable at once.
- R2: With `policy_i` = 2'b00 (squash), and likewise with the spare code 2'b11, a valid access by thread i naming writer w ≠ i sets `squash_o[i]` for exactly one cycle, on the edge after the report.
- R3: With `policy_i` = 2'b01 (stall), such an access records i→w and raises `stall_o[i]` on the next edge. While stalled, thread i's accesses and commit requests are ignored. `stall_o[i]` falls on the same edge that raises `grant_o[w]`.
- R4: With `policy_i` = 2'b10 (order), such an access records i→w without stall or squash. Thread i is not granted a commit while its row holds any bit, and it becomes grantable once w's grant has cleared that bit.
- R5: An access that would close a dependence loop (w already depends, directly or transitively, on i) squashes i instead of recording the edge. Reports in one cycle are taken in ascending thread order, so a loop formed by two reports in the same cycle squashes the higher-numbered reader.
- R6: Every thread that depends directly or transitively on a squashed thread is squashed on the same edge. All squashed threads have their rows and columns cleared, so their later commit requests are granted without waiting.
- R7: At most one bit of `grant_o` is set per cycle. The winner is the first eligible requester at or after a pointer that is zero after reset and moves to one past each winner.
- R8: An access is ignored when its writer is the reader itself, when the reader is granted on that cycle, or when the named writer is granted on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| policy_i | input | 2 | Resolution policy: 00 squash, 01 stall, 10 order, 11 squash |
| acc_valid_i | input | N | Per-thread report of a read hitting another thread's uncommitted write |
| acc_writer_i | input | N*TW | Writer thread number per reader, field i at bits [i*TW +: TW] |
| cmt_req_i | input | N | Per-thread commit request |
| grant_o | output | N | Registered one-hot commit grant, one-cycle pulse |
| squash_o | output | N | Registered squash, one-cycle pulse per squashed thread |
| stall_o | output | N | Registered stall level per thread |

## Verification
All three outputs are flops fed from the current inputs and matrix state. Every grant, squash and stall change caused by stimulus presented before an edge is visible right after that one edge.

The bench changes inputs one time unit after a rising edge and reads the outputs one time unit after the following rising edge. It checks each result exactly one cycle after its cause. A further cycle is used where a pulse must be seen to end.

Whether a dependence was recorded or cleared is shown only through later commit grants. Each scenario therefore follows its accesses with commit requests whose expected grant cycle is worked out from the round-robin pointer.

// File: rtl/cou_pkg.sv
`timescale 1ns/1ps
package cou_pkg;
  typedef enum logic [1:0] {
    POL_SQUASH = 2'b00,
    POL_STALL  = 2'b01,
    POL_ORDER  = 2'b10,
    POL_SPARE  = 2'b11
  } policy_e;
endpackage

// File: rtl/cou_rr_arbiter.sv
`timescale 1ns/1ps
module cou_rr_arbiter #(
  parameter int N  = 4,
  parameter int TW = 2
) (
  input  logic [N-1:0]  req_i,
  input  logic [TW-1:0] ptr_i,
  output logic [N-1:0]  gnt_o,
  output logic [TW-1:0] id_o,
  output logic          any_o
);
  always_comb begin
    gnt_o = '0;
    id_o  = '0;
    any_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!any_o && req_i[(int'(ptr_i) + k) % N]) begin
        any_o = 1'b1;
        gnt_o[(int'(ptr_i) + k) % N] = 1'b1;
        id_o  = TW'((int'(ptr_i) + k) % N);
      end
    end
  end
endmodule

// File: rtl/cou_closure.sv
`timescale 1ns/1ps
module cou_closure #(
  parameter int N = 4
) (
  input  logic [N-1:0][N-1:0] adj_i,
  output logic [N-1:0][N-1:0] reach_o
);
  // Transitive closure: after N passes every path of length up to N is folded in.
  always_comb begin
    reach_o = adj_i;
    for (int it = 0; it < N; it++)
      for (int a = 0; a < N; a++)
        for (int b = 0; b < N; b++)
          if (reach_o[a][b]) reach_o[a] = reach_o[a] | reach_o[b];
  end
endmodule

// File: rtl/chunk_order_unit.sv
`timescale 1ns/1ps
module chunk_order_unit
  import cou_pkg::*;
#(
  parameter int N  = 4,
  parameter int TW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [1:0]      policy_i,
  input  logic [N-1:0]    acc_valid_i,
  input  logic [N*TW-1:0] acc_writer_i,
  input  logic [N-1:0]    cmt_req_i,
  output logic [N-1:0]    grant_o,
  output logic [N-1:0]    squash_o,
  output logic [N-1:0]    stall_o
);
  policy_e pol;
  assign pol = policy_e'(policy_i);

  logic [N-1:0][N-1:0] dep_q, dep_c, dep_a, dep_n, reach_c, reach_a;
  logic [N-1:0]        stall_q, stl_a, stl_n, sq_dir, sq_all, elig, arb_gnt;
  logic [TW-1:0]       ptr_q, arb_id, wr;
  logic [N-1:0]        row_w, bit_w;
  logic                arb_any;

  // Eligible: requesting, not stalled, no outstanding producer.
  always_comb begin
    for (int i = 0; i < N; i++)
      elig[i] = cmt_req_i[i] && !stall_q[i] && (dep_q[i] == '0);
  end

  cou_rr_arbiter #(.N(N), .TW(TW)) u_arb (
    .req_i (elig),
    .ptr_i (ptr_q),
    .gnt_o (arb_gnt),
    .id_o  (arb_id),
    .any_o (arb_any)
  );

  // The committing chunk releases every thread that waited on it.
  always_comb begin
    dep_c = dep_q;
    if (arb_any)
      for (int a = 0; a < N; a++) dep_c[a][arb_id] = 1'b0;
  end

  cou_closure #(.N(N)) u_clo (
    .adj_i   (dep_c),
    .reach_o (reach_c)
  );

  // Accesses taken in ascending thread order; closure kept current per edge.
  always_comb begin
    dep_a   = dep_c;
    reach_a = reach_c;
    stl_a   = stall_q;
    sq_dir  = '0;
    wr      = '0;
    row_w   = '0;
    bit_w   = '0;
    for (int i = 0; i < N; i++) begin
      wr = acc_writer_i[i*TW +: TW];
      if (acc_valid_i[i] && !stall_q[i] && (int'(wr) < N) && (wr != TW'(i)) &&
          !(arb_any && (arb_id == TW'(i) || arb_id == wr))) begin
        if (pol == POL_SQUASH || pol == POL_SPARE) begin
          sq_dir[i] = 1'b1;
        end else if (reach_a[wr][i]) begin
          sq_dir[i] = 1'b1;
        end else begin
          dep_a[i][wr] = 1'b1;
          row_w = reach_a[wr];
          bit_w = '0;
          bit_w[wr] = 1'b1;
          for (int a = 0; a < N; a++)
            if (a == i || reach_a[a][i]) reach_a[a] = reach_a[a] | row_w | bit_w;
          if (pol == POL_STALL) stl_a[i] = 1'b1;
        end
      end
    end
  end

  // Squash spreads to every transitive dependent; their rows and columns go.
  always_comb begin
    for (int a = 0; a < N; a++) begin
      sq_all[a] = sq_dir[a];
      for (int s = 0; s < N; s++)
        if (sq_dir[s] && reach_a[a][s]) sq_all[a] = 1'b1;
    end
    for (int a = 0; a < N; a++) begin
      dep_n[a] = sq_all[a] ? '0 : (dep_a[a] & ~sq_all);
      stl_n[a] = stl_a[a] && !sq_all[a] && (dep_n[a] != '0);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      dep_q    <= '0;
      stall_q  <= '0;
      ptr_q    <= '0;
      grant_o  <= '0;
      squash_o <= '0;
      stall_o  <= '0;
    end else begin
      dep_q    <= dep_n;
      stall_q  <= stl_n;
      if (arb_any) ptr_q <= TW'((int'(arb_id) + 1) % N);
      grant_o  <= arb_gnt;
      squash_o <= sq_all;
      stall_o  <= stl_n;
    end
  end

  // ---------------- assertions ----------------
  a_r7_one_grant: assert property (@(posedge clk_i) disable iff (rst_i)
    $onehot0(grant_o));

  a_r6_grant_not_squashed: assert property (@(posedge clk_i) disable iff (rst_i)
    (grant_o & squash_o) == '0);

  a_r3_stalled_not_granted: assert property (@(posedge clk_i) disable iff (rst_i)
    (grant_o & stall_o) == '0);

  for (genvar i = 0; i < N; i++) begin : g_thr
    a_r4_grant_needs_empty_row: assert property (@(posedge clk_i) disable iff (rst_i)
      grant_o[i] |-> ($past(dep_q[i]) == '0));

    a_r3_release_on_commit: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(stall_o[i]) |-> (grant_o != '0 || squash_o[i]));

    a_r5_no_self_dep: assert property (@(posedge clk_i) disable iff (rst_i)
      !dep_q[i][i]);

    for (genvar j = 0; j < N; j++) begin : g_pair
      if (i != j) begin : g_ne
        a_r5_no_two_loop: assert property (@(posedge clk_i) disable iff (rst_i)
          !(dep_q[i][j] && dep_q[j][i]));

        a_r6_dependent_squashed: assert property (@(posedge clk_i) disable iff (rst_i)
          (squash_o[j] && $past(dep_q[i][j])) |-> squash_o[i]);
      end
    end
  end
endmodule

// File: tb/chunk_order_unit_tb_top.sv
`timescale 1ns/1ps
module chunk_order_unit_tb_top;
  localparam int N  = 4;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    policy;
  logic [N-1:0]  acc_valid;
  logic [N*TW-1:0] acc_writer;
  logic [N-1:0]  cmt_req;
  logic [N-1:0]  grant, squash, stall;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  chunk_order_unit #(.N(N), .TW(TW)) dut_i (
    .clk_i(clk), .rst_i(rst), .policy_i(policy), .acc_valid_i(acc_valid),
    .acc_writer_i(acc_writer), .cmt_req_i(cmt_req),
    .grant_o(grant), .squash_o(squash), .stall_o(stall)
  );

  task automatic chk(input string req, input string what,
                     input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic clr();
    acc_valid = '0; acc_writer = '0; cmt_req = '0;
  endtask

  task automatic acc(input int t, input int w);
    acc_valid[t] = 1'b1;
    acc_writer[t*TW +: TW] = TW'(w);
  endtask

  task automatic do_reset();
    rst = 1'b1; clr(); policy = 2'b00;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  // R1: reset state and empty matrix
  task automatic t_reset();
    do_reset();
    chk("R1", "grant", grant, 4'b0000);
    chk("R1", "squash", squash, 4'b0000);
    chk("R1", "stall", stall, 4'b0000);
    cmt_req = 4'b1111; cyc(); clr();
    chk("R1", "first grant", grant, 4'b0001);
  endtask

  // R2: squash policy and spare code
  task automatic t_squash();
    do_reset(); policy = 2'b00;
    acc(1, 2); cyc(); clr();
    chk("R2", "squash reader", squash, 4'b0010);
    chk("R2", "no stall", stall, 4'b0000);
    cyc();
    chk("R2", "pulse ends", squash, 4'b0000);
    policy = 2'b11; acc(3, 0); cyc(); clr();
    chk("R2", "spare code squashes", squash, 4'b1000);
    cmt_req = 4'b1000; cyc(); clr();
    chk("R2", "no dependence left", grant, 4'b1000);
  endtask

  // R3: stall until producer commits
  task automatic t_stall();
    do_reset(); policy = 2'b01;
    acc(1, 0); cyc(); clr();
    chk("R3", "stall raised", stall, 4'b0010);
    cmt_req = 4'b0010; acc(1, 3); cyc(); clr();
    chk("R3", "stalled request ignored", grant, 4'b0000);
    chk("R3", "still stalled", stall, 4'b0010);
    cmt_req = 4'b0011; cyc(); clr();
    chk("R3", "producer granted", grant, 4'b0001);
    chk("R3", "stall drops with grant", stall, 4'b0000);
    cmt_req = 4'b0010; cyc(); clr();
    chk("R3", "stalled access not recorded", grant, 4'b0010);
  endtask

  // R4: order policy holds back dependent commit
  task automatic t_order();
    do_reset(); policy = 2'b10;
    acc(2, 3); cyc(); clr();
    chk("R4", "no stall", stall, 4'b0000);
    chk("R4", "no squash", squash, 4'b0000);
    cmt_req = 4'b0100; cyc();
    chk("R4", "dependent held", grant, 4'b0000);
    cyc();
    chk("R4", "dependent still held", grant, 4'b0000);
    cmt_req = 4'b1100; cyc();
    chk("R4", "producer first", grant, 4'b1000);
    cmt_req = 4'b0100; cyc(); clr();
    chk("R4", "dependent after producer", grant, 4'b0100);
  endtask

  // R5: loop closing access squashes reader (and R6 spreads it)
  task automatic t_cycle();
    do_reset(); policy = 2'b10;
    acc(0, 1); cyc(); clr();
    acc(1, 2); cyc(); clr();
    chk("R5", "chain accepted", squash, 4'b0000);
    acc(2, 0); cyc(); clr();
    chk("R5", "three-loop squash", squash, 4'b0111);
    acc(0, 1); acc(1, 0); cyc(); clr();
    chk("R5", "same-cycle loop squash", squash, 4'b0011);
    cmt_req = 4'b0011; cyc(); clr();
    chk("R5", "rows cleared", grant, 4'b0001);
  endtask

  // R6: squash propagation to transitive dependents
  task automatic t_propagate();
    do_reset(); policy = 2'b10;
    acc(1, 0); acc(2, 1); cyc(); clr();
    chk("R6", "chain recorded", squash, 4'b0000);
    policy = 2'b00; acc(0, 3); cyc(); clr();
    chk("R6", "dependents squashed", squash, 4'b0111);
    cmt_req = 4'b1110; cyc();
    chk("R6", "row1 cleared", grant, 4'b0010);
    cyc();
    chk("R6", "row2 cleared", grant, 4'b0100);
    cyc(); clr();
    chk("R6", "bystander", grant, 4'b1000);
  endtask

  // R7: round robin, one grant per cycle
  task automatic t_rr();
    do_reset();
    cmt_req = 4'b1111;
    cyc(); chk("R7", "rr 0", grant, 4'b0001);
    cyc(); chk("R7", "rr 1", grant, 4'b0010);
    cyc(); chk("R7", "rr 2", grant, 4'b0100);
    cyc(); chk("R7", "rr 3", grant, 4'b1000);
    cyc(); chk("R7", "rr wrap", grant, 4'b0001);
    cmt_req = 4'b1010;
    cyc(); chk("R7", "rr skip a", grant, 4'b0010);
    cyc(); chk("R7", "rr skip b", grant, 4'b1000);
    cyc(); clr(); chk("R7", "rr skip c", grant, 4'b0010);
  endtask

  // R8: ignored accesses
  task automatic t_ignore();
    do_reset(); policy = 2'b10;
    acc(2, 2); cyc(); clr();
    chk("R8", "self access quiet", squash | stall, 4'b0000);
    cmt_req = 4'b0100; cyc(); clr();
    chk("R8", "self access not recorded", grant, 4'b0100);
    do_reset(); policy = 2'b10;
    cmt_req = 4'b0010; acc(0, 1); cyc(); clr();
    chk("R8", "writer granted", grant, 4'b0010);
    cmt_req = 4'b0001; cyc(); clr();
    chk("R8", "writer-granted access not recorded", grant, 4'b0001);
    do_reset(); policy = 2'b00;
    cmt_req = 4'b0100; acc(2, 0); cyc(); clr();
    chk("R8", "reader granted", grant, 4'b0100);
    chk("R8", "granted reader not squashed", squash, 4'b0000);
  endtask

  initial begin
    t_reset();
    t_squash();
    t_stall();
    t_order();
    t_cycle();
    t_propagate();
    t_rr();
    t_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule